// File: doc/BRIEF.md
# Contact Card Power-Up Sequencer

This block brings up the supply, line drivers and reset of a contact smart card in a fixed order once the host asks for it. The host pulls an active-low command line low while a card is present. The block then asks the internal oscillator to start. After a fixed number of slow oscillator periods it switches the oscillator to its fast rate; that instant is the time reference for everything that follows. The card supply comes on at the reference instant. The three host-side data lines go high after 8.5 units. Card reset is enabled after 11.5 units. One unit is a fixed number of fast periods. Between the line-drive step and the reset step, an output flags the window in which the host may pass its own clock to the card.

The block runs on one system clock. The oscillator reports its periods as single-cycle strobes, one for the slow rate and one for the fast rate, and the sequencer counts those strobes. The command and card-presence inputs are asynchronous, so each passes through a two-flop synchronizer. Activation fires on a falling edge of the synchronized command while the card is present. Deactivation happens when the command goes high again or the card is withdrawn. In either case the outputs fall in the reverse of the order in which they rose, one group per clock cycle, and the block returns to idle.

Top module: `sc_act_seq`

## Requirements
- R1: After reset, every output is low (osc_start, osc_fast, vcc_en, volt_hi, io_hi, clk_window, card_rst_en, active).
- R2: osc_start rises on the third rising clock edge after cmd_n is first sampled low, provided card_present has been high for at least three cycles before that.
- R3: osc_fast and vcc_en rise together on the clock edge that counts the SLOW_CYCLES-th (default 384) slow_tick received after osc_start rose.
- R4: All three bits of io_hi (bit 0 data line, bit 1 first auxiliary line, bit 2 second auxiliary line) rise together on the edge that counts the IO_HALF_UNITS*UNIT_CYCLES/2-th fast_tick after vcc_en rose (default 544).
- R5: clk_window rises on the edge that counts the fast_tick after the one that raised io_hi. It falls on the same edge on which card_rst_en rises, so it is never high together with card_rst_en.
- R6: card_rst_en and active rise together on the edge that counts the RST_HALF_UNITS*UNIT_CYCLES/2-th fast_tick after vcc_en rose (default 736). Both stay high while cmd_n stays low and the card stays present.
- R7: volt_hi (1 = higher supply level, 0 = lower) takes the value of volt_sel on the edge where activation starts. Later changes of volt_sel have no effect on volt_hi until the next activation.
- R8: If cmd_n goes high or card_present goes low during a sequence, the outputs start to fall on the third edge after the change is first sampled. They fall one step per cycle in this order, each step an edge: card_rst_en with active and clk_window; then io_hi; then vcc_en; then osc_fast; then osc_start. A step whose outputs are already low is skipped.
- R9: If the abort reaches the sequencer on the same edge as a rising step, the abort takes priority and that step never appears on the outputs.
- R10: No activation starts while card_present is low. Holding cmd_n low does not start an activation when the card arrives later; a new falling edge of cmd_n is required.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_n | input | 1 | Asynchronous active-low activation command from the host |
| card_present | input | 1 | Asynchronous card-presence flag, high when a card is inserted |
| volt_sel | input | 1 | Supply level choice: 1 higher, 0 lower |
| slow_tick | input | 1 | One-cycle strobe per slow oscillator period |
| fast_tick | input | 1 | One-cycle strobe per fast oscillator period |
| osc_start | output | 1 | Request to start the internal oscillator |
| osc_fast | output | 1 | Request to switch the oscillator to its fast rate |
| vcc_en | output | 1 | Card supply enable |
| volt_hi | output | 1 | Latched supply level choice |
| io_hi | output | 3 | Drive-high enables for data line, auxiliary line 1, auxiliary line 2 |
| clk_window | output | 1 | High while the host may apply the card clock |
| card_rst_en | output | 1 | Card reset pin enabled |
| active | output | 1 | Sequence completed and card powered |

## Verification
Two functions can fall on the same edge: a teardown triggered by the command rising, and the last rising step that enables card reset. The bench forces a fast strobe on every cycle so that the reset step lands on a known edge. It then raises cmd_n at a swept offset from the observed rise of io_hi, so that the synchronized abort reaches the sequencer one or two edges before the reset step, on the same edge, or after it. For each offset the bench predicts whether card_rst_en may ever be seen high. Every teardown is also judged step by step against the required fall order.

// File: rtl/sc_act_pkg.sv
// Package: shared types and helpers for the card power-up sequencer.
// Assumes: levels are ordered so that a higher level means more outputs on.
package sc_act_pkg;

    // Progress level of the sequence; outputs are a pure decode of this.
    typedef enum logic [2:0] {
        LV_IDLE   = 3'd0,
        LV_OSC    = 3'd1,
        LV_FAST   = 3'd2,
        LV_SUPPLY = 3'd3,
        LV_IO     = 3'd4,
        LV_WIN    = 3'd5,
        LV_RST    = 3'd6
    } lvl_e;

    // Next level on the way down; the window level is skipped from reset.
    function automatic lvl_e lvl_down(input lvl_e l);
        case (l)
            LV_IDLE: return LV_IDLE;
            LV_RST:  return LV_IO;
            default: return lvl_e'(l - 3'd1);
        endcase
    endfunction

endpackage

// File: rtl/sc_sync2.sv
// Module: two-flop synchronizer for asynchronous control inputs.
// Assumes: each bit is independent; RST_VAL gives the safe value after reset.
module sc_sync2 #(
    parameter int         W       = 1,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta;

    // Two register stages in series toward the clock domain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta <= RST_VAL;
            q    <= RST_VAL;
        end else begin
            meta <= d;
            q    <= meta;
        end
    end
endmodule

// File: rtl/sc_tick_count.sv
// Module: strobe counter with synchronous clear, sized for a maximum count.
// Assumes: the owner stops enabling it before MAX is exceeded.
module sc_tick_count #(
    parameter  int MAX = 384,
    localparam int W   = $clog2(MAX + 1)
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         en,
    output logic [W-1:0] count
);
    // Clear wins over counting; count one per enabled strobe.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) count <= '0;
        else if (en)       count <= count + W'(1);
    end

    // R3 / R4: the owner never asks for a step past the top of the range.
    a_r3_count_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !clr) |-> (count < W'(MAX)));
endmodule

// File: rtl/sc_out_decode.sv
// Module: turns the progress level into the sequenced enable outputs.
// Assumes: level only moves by the steps the sequencer allows.
module sc_out_decode
    import sc_act_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  lvl_e       level,
    output logic       osc_start,
    output logic       osc_fast,
    output logic       vcc_en,
    output logic [2:0] io_hi,
    output logic       clk_window,
    output logic       card_rst_en,
    output logic       active
);
    // Thermometer decode of the level into the output groups.
    always_comb begin
        osc_start   = (level >= LV_OSC);
        osc_fast    = (level >= LV_FAST);
        vcc_en      = (level >= LV_SUPPLY);
        io_hi       = {3{level >= LV_IO}};
        clk_window  = (level == LV_WIN);
        card_rst_en = (level == LV_RST);
        active      = (level == LV_RST);
    end

    // R5: reset is only ever enabled straight out of an open clock window.
    a_r5_window_before_reset: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(card_rst_en) |-> $past(clk_window));

    // R8: once reset drops in a teardown the window does not reopen.
    a_r8_no_window_reopen: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(card_rst_en) |=> !clk_window);

    // R8: supply drops only after the line drivers are already off.
    a_r8_lines_before_supply: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(vcc_en) |-> ($past(io_hi) == 3'b000));
endmodule

// File: rtl/sc_act_seq.sv
// Module: top of the contact card power-up sequencer.
// Does:   counts slow strobes to the fast-switch instant, then fast strobes
//         to line drive, clock window and reset enable; tears down in reverse
//         on command release or card removal.
// Assumes: slow_tick / fast_tick are one-cycle strobes in the clk domain;
//          RST half-units exceed IO half-units by enough for a window.
module sc_act_seq
    import sc_act_pkg::*;
#(
    parameter int SLOW_CYCLES    = 384,
    parameter int UNIT_CYCLES    = 64,
    parameter int IO_HALF_UNITS  = 17,
    parameter int RST_HALF_UNITS = 23
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cmd_n,
    input  logic       card_present,
    input  logic       volt_sel,
    input  logic       slow_tick,
    input  logic       fast_tick,
    output logic       osc_start,
    output logic       osc_fast,
    output logic       vcc_en,
    output logic       volt_hi,
    output logic [2:0] io_hi,
    output logic       clk_window,
    output logic       card_rst_en,
    output logic       active
);
    localparam int IO_CYC  = IO_HALF_UNITS  * UNIT_CYCLES / 2;
    localparam int RST_CYC = RST_HALF_UNITS * UNIT_CYCLES / 2;
    localparam int SW      = $clog2(SLOW_CYCLES + 1);
    localparam int FW      = $clog2(RST_CYC + 1);

    logic          cmd_s, pres_s;
    logic          cmd_act, cmd_act_q;
    logic          start_ok, abort_w;
    logic          falling;
    lvl_e          level;
    logic          sel_q;
    logic [SW-1:0] scnt;
    logic [FW-1:0] fcnt;
    logic          slow_en, fast_en, slow_clr, fast_clr;

    sc_sync2 #(.W(2), .RST_VAL(2'b01)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({card_present, cmd_n}),
        .q     ({pres_s, cmd_s})
    );

    // Request conditions from the synchronized host inputs.
    always_comb begin
        cmd_act  = ~cmd_s;
        start_ok = cmd_act & ~cmd_act_q & pres_s;
        abort_w  = (level != LV_IDLE) & ~falling & (~cmd_act | ~pres_s);
    end

    // Counter enables: slow strobes before the switch, fast strobes after.
    always_comb begin
        slow_clr = (level == LV_IDLE);
        slow_en  = slow_tick & (level == LV_OSC) & ~falling;
        fast_clr = (level <= LV_OSC);
        fast_en  = fast_tick & ~falling & (level >= LV_SUPPLY) & (level <= LV_WIN);
    end

    sc_tick_count #(.MAX(SLOW_CYCLES)) u_slow_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (slow_clr),
        .en    (slow_en),
        .count (scnt)
    );

    sc_tick_count #(.MAX(RST_CYC)) u_fast_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (fast_clr),
        .en    (fast_en),
        .count (fcnt)
    );

    // Edge memory of the synchronized command.
    always_ff @(posedge clk) begin
        if (!rst_n) cmd_act_q <= 1'b0;
        else        cmd_act_q <= cmd_act;
    end

    // Sequence level: teardown first, abort next, otherwise the rising steps.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            level   <= LV_IDLE;
            falling <= 1'b0;
            sel_q   <= 1'b0;
        end else if (falling) begin
            level <= lvl_down(level);
            if (lvl_down(level) == LV_IDLE) falling <= 1'b0;
        end else if (abort_w) begin
            level   <= lvl_down(level);
            falling <= (lvl_down(level) != LV_IDLE);
        end else begin
            case (level)
                LV_IDLE: if (start_ok) begin
                    level <= LV_OSC;
                    sel_q <= volt_sel;
                end
                LV_OSC: if (slow_tick && scnt == SW'(SLOW_CYCLES - 1))
                    level <= LV_SUPPLY;
                LV_SUPPLY: if (fast_tick && fcnt == FW'(IO_CYC - 1))
                    level <= LV_IO;
                LV_IO: if (fast_tick && fcnt == FW'(IO_CYC))
                    level <= LV_WIN;
                LV_WIN: if (fast_tick && fcnt == FW'(RST_CYC - 1))
                    level <= LV_RST;
                default: ;
            endcase
        end
    end

    sc_out_decode u_dec (
        .clk         (clk),
        .rst_n       (rst_n),
        .level       (level),
        .osc_start   (osc_start),
        .osc_fast    (osc_fast),
        .vcc_en      (vcc_en),
        .io_hi       (io_hi),
        .clk_window  (clk_window),
        .card_rst_en (card_rst_en),
        .active      (active)
    );

    // Latched supply choice.
    always_comb volt_hi = sel_q;

    // R2: a start only happens with the card reported present.
    a_r2_start_needs_card: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(osc_start) |-> $past(pres_s));

    // R3: the fast switch is caused by a counted slow strobe.
    a_r3_fast_on_slow_tick: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(osc_fast) |-> $past(slow_tick));

    // R7: the supply choice holds for the whole sequence.
    a_r7_sel_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (osc_start && $past(osc_start)) |-> $stable(volt_hi));

    // R9: an abort on the reset step edge leaves reset disabled.
    a_r9_abort_wins: assert property (@(posedge clk) disable iff (!rst_n)
        abort_w |=> !card_rst_en);

    // R6: reset stays enabled while the host holds the request with a card.
    a_r6_reset_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (card_rst_en && cmd_act && pres_s && !falling) |=> card_rst_en);
endmodule

// File: tb/sc_act_seq_test.sv
module sc_act_seq_test;
    localparam int SLOW = 384;
    localparam int IOC  = 544;
    localparam int RSTC = 736;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cmd_n = 1'b1;
    logic card_present = 1'b0;
    logic volt_sel = 1'b0;
    logic slow_tick = 1'b0;
    logic fast_tick = 1'b0;
    logic osc_start, osc_fast, vcc_en, volt_hi, clk_window, card_rst_en, active;
    logic [2:0] io_hi;

    int nchk = 0;
    int nfail = 0;
    bit finished = 0;
    int slow_per = 2;
    int fast_den = 1;
    bit fast_force = 0;
    int cyc = 0;

    always #10 clk = ~clk;

    sc_act_seq uut (
        .clk(clk), .rst_n(rst_n), .cmd_n(cmd_n), .card_present(card_present),
        .volt_sel(volt_sel), .slow_tick(slow_tick), .fast_tick(fast_tick),
        .osc_start(osc_start), .osc_fast(osc_fast), .vcc_en(vcc_en),
        .volt_hi(volt_hi), .io_hi(io_hi), .clk_window(clk_window),
        .card_rst_en(card_rst_en), .active(active)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int rank_of();
        return int'(osc_start) + int'(osc_fast) + int'(vcc_en) + int'(io_hi == 3'b111)
             + int'(clk_window | card_rst_en) + int'(card_rst_en);
    endfunction

    function automatic bit shape_ok();
        return (osc_start >= osc_fast) && (osc_fast >= vcc_en)
            && (vcc_en >= io_hi[0]) && (io_hi == 3'b000 || io_hi == 3'b111)
            && !(clk_window && card_rst_en) && (active == card_rst_en)
            && (io_hi[0] >= card_rst_en) && (io_hi[0] >= clk_window);
    endfunction

    function automatic int down_of(input int r);
        if (r == 6) return 4;
        if (r > 0) return r - 1;
        return 0;
    endfunction

    // Strobe generator: slow strobe periodic, fast strobe random or forced.
    initial begin
        forever begin
            @(posedge clk); #1;
            cyc++;
            slow_tick = (slow_per != 0) && (cyc % slow_per == 0);
            fast_tick = fast_force || ($urandom_range(fast_den - 1, 0) == 0);
        end
    end

    // Monitor: counts strobes the way the requirements define and checks steps.
    int  scount = 0, fcount = 0;
    logic p_fast = 0, p_io = 0, p_win = 0, p_rst = 0;
    bit  mon_en = 0;
    always @(negedge clk) begin
        if (mon_en) begin
            if (osc_fast && !p_fast)
                chk(scount == SLOW && vcc_en, "R3 fast switch slow count", scount, SLOW);
            if (io_hi[0] && !p_io)
                chk(fcount == IOC && io_hi == 3'b111, "R4 line drive fast count", fcount, IOC);
            if (clk_window && !p_win)
                chk(fcount == IOC + 1, "R5 window open fast count", fcount, IOC + 1);
            if (card_rst_en && !p_rst) begin
                chk(fcount == RSTC && active, "R6 reset fast count", fcount, RSTC);
                chk(p_win && !clk_window, "R5 window closes with reset", clk_window, 0);
            end
            if (!shape_ok()) chk(0, "R8 output shape", rank_of(), -1);
        end
        p_fast = osc_fast; p_io = io_hi[0]; p_win = clk_window; p_rst = card_rst_en;
        if (!osc_start) scount = 0;
        else if (!osc_fast && slow_tick) scount++;
        if (!vcc_en) fcount = 0;
        else if (!card_rst_en && fast_tick) fcount++;
    end

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic wait_active(output bit ok);
        ok = 0;
        for (int i = 0; i < 20000; i++) begin
            @(negedge clk);
            if (active) begin ok = 1; break; end
        end
    endtask

    task automatic wait_idle(input string req);
        bit ok = 0;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            if (rank_of() == 0) begin ok = 1; break; end
        end
        chk(ok, req, rank_of(), 0);
    endtask

    // Start a sequence from idle; returns the supply choice that was latched.
    task automatic activate(input bit sel, output bit latched);
        volt_sel = sel;
        step(1);
        cmd_n = 1'b0;
        latched = sel;
        step(6);
        volt_sel = ~sel;
    endtask

    // Abort through the command (by_pres=0) or card removal, then check order.
    task automatic abort_seq(input bit by_pres);
        int rprev, rnow;
        step(1);
        if (by_pres) card_present = 1'b0; else cmd_n = 1'b1;
        @(negedge clk); @(negedge clk); @(negedge clk);
        rprev = rank_of();
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            rnow = rank_of();
            chk(rnow == down_of(rprev), "R8 teardown step", rnow, down_of(rprev));
            rprev = rnow;
            if (rnow == 0) break;
        end
        chk(rank_of() == 0 && !clk_window, "R8 teardown reaches idle", rank_of(), 0);
        step(1);
        cmd_n = 1'b1;
        card_present = 1'b1;
        step(4);
    endtask

    // Watchdog: a hang counts as a failed check.
    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            nfail++;
            $display("FAIL watchdog actual=%0d expected=%0d", 190000, 0);
            $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
            $finish;
        end
    end

    initial begin
        bit ok, lat, seen;
        int delay, mode;
        void'($urandom(32'h5eed_0a11));
        step(5);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk(rank_of() == 0 && !volt_hi && io_hi == 0, "R1 reset outputs", rank_of(), 0);
        mon_en = 1;

        // R10: no card, then card arrives with command already low
        card_present = 1'b0;
        cmd_n = 1'b0;
        step(10);
        chk(!osc_start, "R10 no start without card", osc_start, 0);
        card_present = 1'b1;
        step(10);
        chk(!osc_start, "R10 held command needs new edge", osc_start, 0);
        cmd_n = 1'b1;
        step(6);

        // R2: latency of start through synchronizer
        volt_sel = 1'b1;
        cmd_n = 1'b0;
        @(negedge clk); @(negedge clk); @(negedge clk);
        chk(!osc_start, "R2 start not before third edge", osc_start, 0);
        @(negedge clk);
        chk(osc_start, "R2 start on third edge", osc_start, 1);
        step(2);
        volt_sel = 1'b0;
        wait_active(ok);
        chk(ok, "R6 reaches active", ok, 1);
        chk(volt_hi == 1'b1, "R7 latched choice", volt_hi, 1);
        step(50);
        @(negedge clk);
        chk(card_rst_en && active, "R6 reset held", card_rst_en, 1);
        abort_seq(0);

        // R9: abort against the reset step, swept around the shared edge
        fast_force = 1;
        slow_per = 1;
        for (int d = 186; d <= 192; d++) begin
            activate(1'b0, lat);
            ok = 0;
            for (int i = 0; i < 3000; i++) begin
                @(negedge clk);
                if (io_hi == 3'b111) begin ok = 1; break; end
            end
            chk(ok, "R4 lines reached", ok, 1);
            repeat (d) @(posedge clk);
            #1 cmd_n = 1'b1;
            seen = 0;
            for (int i = 0; i < 14; i++) begin
                @(negedge clk);
                if (card_rst_en) seen = 1;
            end
            chk(seen == (d >= 190), "R9 abort versus reset step", seen, int'(d >= 190));
            chk(rank_of() == 0, "R8 idle after sweep abort", rank_of(), 0);
            step(4);
        end
        fast_force = 0;

        // Random sequences with random aborts
        for (int it = 0; it < 16; it++) begin
            slow_per = $urandom_range(3, 1);
            fast_den = $urandom_range(3, 1);
            mode = $urandom_range(3, 0);
            activate(1'($urandom_range(1, 0)), lat);
            if (mode < 2) begin
                wait_active(ok);
                chk(ok, "R6 random reaches active", ok, 1);
                chk(volt_hi == lat, "R7 random latched choice", volt_hi, lat);
            end else begin
                delay = $urandom_range(3500, 0);
                repeat (delay) @(posedge clk);
            end
            abort_seq(mode[0]);
        end

        wait_idle("R8 final idle");
        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end
endmodule